// File: doc/BRIEF.md
# Wired and Message Interrupt Aggregator

This block gathers 64 interrupt sources into one level output for a parent interrupt controller. Sources 0 to 20 are level-high wires sampled every clock. Sources 21 to 63 have no wires. A requester raises one of them by writing that source's number to a doorbell register. Every source owns a sticky pending bit in one of two 32-bit cause registers. Source n sits in the cause register for bank n/32, at bit n%32.

Software reaches the block through a simple 32-bit register port. Writes are strobed. Read data is combinational from the address. Software scans both cause registers and handles each pending bit. It retires a bit by writing a one to it. Two mask registers, one for each bank, decide which pending bits can raise the parent output. A mask bit of one blocks its source. The parent output is registered.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both cause registers read 0, both mask registers read 0xFFFFFFFF, and `irq_out` is 0.
- R2: Source n is reported in the cause register at byte offset 0x00 when n < 32, and at offset 0x04 otherwise, at bit n%32.
- R3: While wired input i (0 to 20) is high, cause bit i becomes set. The bit stays set after the wire falls.
- R4: A write to offset 0x30 with a data value from 21 to 63 sets the cause bit of that source. Any other data value leaves both cause registers unchanged.
- R5: A write to a cause register clears each bit written as 1. Bits written as 0 keep their value.
- R6: When a set and a write-one clear meet on the same bit, the set wins. A wired source that is still high therefore reads as pending after it is cleared.
- R7: The mask registers at offsets 0x20 (bank 0) and 0x24 (bank 1) read back the value last written. A mask bit of 1 stops its pending bit from reaching `irq_out`.
- R8: `irq_out` equals, one clock late, the OR of all cause bits whose mask bit is 0.
- R9: A read from any offset other than 0x00, 0x04, 0x20 and 0x24 returns 0. A write to an offset other than those four and 0x30 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wired_lvl | input | 21 | Level-high wired sources 0 to 20 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Level interrupt to the parent controller |

## Verification
Two events can hit the same cause bit in one clock: the capture of a wired source that is still high, and a write-one clear from software. To provoke this, the bench holds a wire high across a clear of that bit. It then reads the cause register and expects the bit to still be set. It then drops the wire, clears the bit again, and expects the bit to read 0. Random rounds mix wire pulses, doorbell writes (including out-of-range values), clears and mask writes. After each round the bench compares every register and `irq_out` with its own model.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

    localparam int SRC_COUNT    = 64;
    localparam int BANK_W       = 32;
    localparam int BANK_COUNT   = SRC_COUNT / BANK_W;
    localparam int WIRED_COUNT  = 21;
    localparam int ADDR_W       = 8;
    localparam int DATA_W       = 32;
    localparam int BANK_STRIDE  = 4;
    localparam int SRC_IDX_W    = $clog2(SRC_COUNT);
    localparam int BANK_IDX_W   = (BANK_COUNT > 1) ? $clog2(BANK_COUNT) : 1;

    localparam logic [ADDR_W-1:0] OFS_CAUSE_BASE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MASK_BASE  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DOORBELL   = 8'h30;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_MASK,
        SEL_DOORBELL
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e                sel;
        logic [BANK_IDX_W-1:0]   bank;
    } addr_dec_t;

    typedef struct packed {
        logic [SRC_COUNT-1:0]    clr;
        logic [SRC_COUNT-1:0]    msg_set;
        logic [BANK_COUNT-1:0]   mask_we;
        logic [BANK_W-1:0]       mask_wdata;
    } wr_cmd_t;

    function automatic addr_dec_t decode_addr(input logic [ADDR_W-1:0] a);
        addr_dec_t r;
        r.sel  = SEL_NONE;
        r.bank = '0;
        if (a == OFS_DOORBELL) begin
            r.sel = SEL_DOORBELL;
        end
        for (int b = 0; b < BANK_COUNT; b++) begin
            if (a == OFS_CAUSE_BASE + ADDR_W'(b * BANK_STRIDE)) begin
                r.sel  = SEL_CAUSE;
                r.bank = BANK_IDX_W'(b);
            end
            if (a == OFS_MASK_BASE + ADDR_W'(b * BANK_STRIDE)) begin
                r.sel  = SEL_MASK;
                r.bank = BANK_IDX_W'(b);
            end
        end
        return r;
    endfunction

    function automatic logic msg_in_range(input logic [DATA_W-1:0] d);
        return (d >= DATA_W'(WIRED_COUNT)) && (d < DATA_W'(SRC_COUNT));
    endfunction

endpackage

// File: rtl/irqagg_wired_capture.sv
module irqagg_wired_capture
    import irqagg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIRED_COUNT-1:0] wired_lvl,
    output logic [SRC_COUNT-1:0]   wired_set
);

    logic [WIRED_COUNT-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else begin
            lvl_q <= wired_lvl;
        end
    end

    always_comb begin
        wired_set = '0;
        wired_set[WIRED_COUNT-1:0] = lvl_q;
    end

    // R3: a captured level tracks the input one clock later
    p_capture_follows_r3: assert property (@(posedge clk) disable iff (rst)
        wired_set[WIRED_COUNT-1:0] == $past(wired_lvl));

endmodule

// File: rtl/irqagg_decode.sv
module irqagg_decode
    import irqagg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [SRC_COUNT-1:0]  cause_all,
    input  logic [SRC_COUNT-1:0]  mask_all,
    output wr_cmd_t               cmd,
    output logic [DATA_W-1:0]     rdata
);

    addr_dec_t dec;

    always_comb begin
        dec = decode_addr(addr);
        cmd = '0;
        if (wr_en) begin
            unique case (dec.sel)
                SEL_CAUSE: cmd.clr[dec.bank*BANK_W +: BANK_W] = wdata[BANK_W-1:0];
                SEL_MASK: begin
                    cmd.mask_we[dec.bank] = 1'b1;
                    cmd.mask_wdata        = wdata[BANK_W-1:0];
                end
                SEL_DOORBELL: begin
                    if (msg_in_range(wdata)) begin
                        cmd.msg_set[wdata[SRC_IDX_W-1:0]] = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (dec.sel)
            SEL_CAUSE: rdata = DATA_W'(cause_all[dec.bank*BANK_W +: BANK_W]);
            SEL_MASK:  rdata = DATA_W'(mask_all[dec.bank*BANK_W +: BANK_W]);
            default:   rdata = '0;
        endcase
    end

    // R4: one doorbell write raises at most one source
    p_doorbell_single_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd.msg_set));

    // R4: the doorbell never reaches a wired source
    p_doorbell_not_wired_r4: assert property (@(posedge clk) disable iff (rst)
        cmd.msg_set[WIRED_COUNT-1:0] == '0);

    // R9: without a write strobe no register is touched
    p_idle_no_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (cmd.clr == '0 && cmd.msg_set == '0 && cmd.mask_we == '0));

endmodule

// File: rtl/irqagg_cause_bank.sv
module irqagg_cause_bank
    import irqagg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] set_vec,
    input  logic [BANK_W-1:0] clr_vec,
    input  logic              mask_we,
    input  logic [BANK_W-1:0] mask_wdata,
    output logic [BANK_W-1:0] cause_q,
    output logic [BANK_W-1:0] mask_q,
    output logic              pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q <= (cause_q & ~clr_vec) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    assign pend = |(cause_q & ~mask_q);

    // R6: a set request always lands, even against a clear
    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (cause_q & $past(set_vec)) == $past(set_vec));

    // R5: a cleared bit with no set request reads 0
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (cause_q & $past(clr_vec) & ~$past(set_vec)) == '0);

    // R5: a pending bit not cleared stays pending
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (($past(cause_q) & ~$past(clr_vec)) & ~cause_q) == '0);

    // R7: a mask value is only changed by its own write
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(mask_we) |-> $stable(mask_q));

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irqagg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIRED_COUNT-1:0] wired_lvl,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [DATA_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   irq_out
);

    wr_cmd_t                cmd;
    logic [SRC_COUNT-1:0]   wired_set;
    logic [SRC_COUNT-1:0]   set_all;
    logic [SRC_COUNT-1:0]   cause_all;
    logic [SRC_COUNT-1:0]   mask_all;
    logic [BANK_COUNT-1:0]  bank_pend;
    logic                   irq_q;

    irqagg_wired_capture u_capture (
        .clk       (clk),
        .rst       (rst),
        .wired_lvl (wired_lvl),
        .wired_set (wired_set)
    );

    irqagg_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cause_all (cause_all),
        .mask_all  (mask_all),
        .cmd       (cmd),
        .rdata     (reg_rdata)
    );

    assign set_all = wired_set | cmd.msg_set;

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
        irqagg_cause_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .set_vec    (set_all[b*BANK_W +: BANK_W]),
            .clr_vec    (cmd.clr[b*BANK_W +: BANK_W]),
            .mask_we    (cmd.mask_we[b]),
            .mask_wdata (cmd.mask_wdata),
            .cause_q    (cause_all[b*BANK_W +: BANK_W]),
            .mask_q     (mask_all[b*BANK_W +: BANK_W]),
            .pend       (bank_pend[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |bank_pend;
        end
    end

    assign irq_out = irq_q;

    // R8: output follows unmasked pending state with one clock of delay
    p_irq_latency_r8: assert property (@(posedge clk) disable iff (rst)
        irq_out == $past(|(cause_all & ~mask_all)));

    // R1: the first cycle after reset shows the reset state
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_all == '1 && cause_all == '0 && !irq_out));

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

    localparam time CLK_HALF = 10ns;
    localparam int  WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] wired_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int n_checks = 0;
    int n_fails  = 0;

    logic [63:0] exp_cause = '0;
    logic [63:0] exp_mask  = '1;

    always #CLK_HALF clk = ~clk;

    irq_aggregator i_irq_aggregator (
        .clk       (clk),
        .rst       (rst),
        .wired_lvl (wired_lvl),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1ns;
        d = reg_rdata;
    endtask

    function automatic logic exp_irq();
        return |(exp_cause & ~exp_mask);
    endfunction

    function automatic logic [63:0] model_doorbell(input logic [63:0] c, input logic [31:0] d);
        logic [63:0] r = c;
        if (d >= 32'd21 && d < 32'd64) r[d[5:0]] = 1'b1;
        return r;
    endfunction

    task automatic check_all(input string req);
        logic [31:0] v;
        reg_read(8'h00, v); check({req, " R2 cause0"}, 64'(v), 64'(exp_cause[31:0]));
        reg_read(8'h04, v); check({req, " R2 cause1"}, 64'(v), 64'(exp_cause[63:32]));
        reg_read(8'h20, v); check({req, " R7 mask0"},  64'(v), 64'(exp_mask[31:0]));
        reg_read(8'h24, v); check({req, " R7 mask1"},  64'(v), 64'(exp_mask[63:32]));
        check({req, " R8 irq"}, 64'(irq_out), 64'(exp_irq()));
    endtask

    task automatic wired_pulse(input logic [20:0] v);
        @(negedge clk);
        wired_lvl = v;
        repeat (3) @(negedge clk);
        wired_lvl = '0;
        repeat (3) @(negedge clk);
        exp_cause[20:0] = exp_cause[20:0] | v;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check_all("R1");

        // R9: undefined offsets read 0, writes there change nothing
        reg_read(8'h08, v); check("R9 read 0x08", 64'(v), 64'h0);
        reg_read(8'h30, v); check("R9 read 0x30", 64'(v), 64'h0);
        reg_read(8'h2C, v); check("R9 read 0x2C", 64'(v), 64'h0);
        reg_write(8'h10, 32'h0000_0000);
        reg_write(8'h28, 32'h0000_0000);
        check_all("R9 stray write");

        // R4: out-of-range doorbell values are ignored
        reg_write(8'h30, 32'd20);
        reg_write(8'h30, 32'd0);
        reg_write(8'h30, 32'd64);
        reg_write(8'h30, 32'hFFFF_FFFF);
        check_all("R4 ignored");

        // R2, R4: edge sources land at the right bank and bit
        reg_write(8'h30, 32'd21); exp_cause = model_doorbell(exp_cause, 32'd21);
        reg_write(8'h30, 32'd31); exp_cause = model_doorbell(exp_cause, 32'd31);
        reg_write(8'h30, 32'd32); exp_cause = model_doorbell(exp_cause, 32'd32);
        reg_write(8'h30, 32'd63); exp_cause = model_doorbell(exp_cause, 32'd63);
        check("R2 map", exp_cause, 64'h8000_0001_8020_0000);
        check_all("R4 set");

        // R8: one clock from mask change to the output
        reg_write(8'h24, 32'hFFFF_FFFE); exp_mask[63:32] = 32'hFFFF_FFFE;
        check("R8 irq before edge", 64'(irq_out), 64'h0);
        @(negedge clk);
        check("R8 irq after edge", 64'(irq_out), 64'h1);

        // R5: write one clears, zero keeps
        reg_write(8'h04, 32'h0000_0000);
        check_all("R5 zero write");
        reg_write(8'h04, 32'h0000_0001); exp_cause[32] = 1'b0;
        check("R8 irq before clear seen", 64'(irq_out), 64'h1);
        @(negedge clk);
        check("R8 irq after clear", 64'(irq_out), 64'h0);
        check_all("R5 clear");

        // R3: wired level sets sticky bit
        wired_pulse(21'h10_0004);
        check_all("R3 wired");

        // R6: held wire against a clear of its bit
        @(negedge clk);
        wired_lvl = 21'h00_0020;
        repeat (3) @(negedge clk);
        exp_cause[5] = 1'b1;
        reg_write(8'h00, 32'h0000_0020 | 32'h8000_0000);
        exp_cause[31] = 1'b0;
        check_all("R6 set wins");
        wired_lvl = '0;
        repeat (2) @(negedge clk);
        reg_write(8'h00, 32'h0000_0020); exp_cause[5] = 1'b0;
        check_all("R6 release");

        // Random rounds for R3 R4 R5 R7 R8
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 3);
            case (op)
                0: wired_pulse(21'($urandom));
                1: begin
                    logic [31:0] d = 32'($urandom_range(0, 80));
                    reg_write(8'h30, d);
                    exp_cause = model_doorbell(exp_cause, d);
                end
                2: begin
                    logic b = 1'($urandom);
                    logic [31:0] d = $urandom;
                    reg_write(b ? 8'h04 : 8'h00, d);
                    if (b) exp_cause[63:32] = exp_cause[63:32] & ~d;
                    else   exp_cause[31:0]  = exp_cause[31:0]  & ~d;
                end
                default: begin
                    logic b = 1'($urandom);
                    logic [31:0] d = $urandom;
                    reg_write(b ? 8'h24 : 8'h20, d);
                    if (b) exp_mask[63:32] = d;
                    else   exp_mask[31:0]  = d;
                end
            endcase
            check_all("R5 R7 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule